// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter with Clear-to-Send Gating

This block serialises words onto a single idle-high line as asynchronous frames. A one-word holding buffer sits in front of the shift engine, so one word can be queued while another is on the wire. Each frame is a low start bit, then 7, 8 or 9 data bits sent least significant bit first, then an optional parity bit and one or two high stop bits. The bit period comes from a programmable divisor that counts pulses of a count-source enable. All logic runs on one clock.

Optional flow control uses an active-low clear-to-send input. It passes through a two-stage synchroniser. It is sampled when a frame ends and, in idle, on every cycle. While it is high, no new frame starts. A transmit-enable input stops new frames from starting. The frame already on the wire always finishes.

The block has three status outputs: a buffer-empty flag, a transmitter-idle flag and a latched interrupt request. The interrupt request is set either when the buffer empties or when the shift engine finishes a frame and goes quiet. An acknowledge strobe clears it.

Top module: `uart_tx_buffered`

## Requirements
- R1: One bit lasts 16 × (baud_div + 1) pulses of cnt_en. With cnt_en held high this is exactly that many clock cycles. Counting begins at the clock edge that starts the frame.
- R2: A frame begins with one low start bit. The data bits follow, D0 first. len_sel encodes the data length: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits, and 3 also gives 8 bits.
- R3: When par_en is 1, one parity bit follows the data. With par_odd = 0 the data bits plus the parity bit hold an even number of ones. With par_odd = 1 they hold an odd number.
- R4: The frame ends with one high stop bit when two_stop = 0 and with two high stop bits when two_stop = 1.
- R5: A wr_stb pulse loads wr_data into the buffer and drives buf_empty low from the next cycle. When the shift engine takes the word, buf_empty returns high, so a second word can be queued during a frame.
- R6: A write that arrives while the buffer still holds a word replaces that word. buf_empty stays low, and only the last word written is sent.
- R7: tx_idle is low while a frame is shifting or a word is waiting. It goes high only after the last stop bit ends with the buffer empty, and while it is high txd is high.
- R8: When cts_en is 0, a queued word starts at the clock edge that ends the previous stop bit, leaving no idle gap.
- R9: When cts_en is 1 and cts_n is high, no new frame starts and txd stays high. After cts_n falls, the start bit appears on the third clock edge, because cts_n passes through a two-flip-flop synchroniser.
- R10: While tx_en is 0, no new frame starts. A frame already started runs to its last stop bit. When tx_en rises with a word waiting, the start bit appears on the next clock edge.
- R11: When irq_on_done is 0, irq is set on the edge where the buffer hands its word to the shift engine. When irq_on_done is 1, irq is set on the edge where a frame ends and no new frame follows.
- R12: Once set, irq stays high until an irq_ack pulse clears it. A new set event in the same cycle as irq_ack takes priority over the clear.
- R13: After reset, txd is high, buf_empty and tx_idle are 1, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-source enable pulse for the bit-rate divider |
| baud_div | input | DIV_W | Divisor n; one bit lasts 16(n+1) enable pulses |
| tx_en | input | 1 | Allows new frames to start |
| len_sel | input | 2 | Data length: 0=7, 1=8, 2=9, 3=8 bits |
| par_en | input | 1 | Adds a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| irq_on_done | input | 1 | Interrupt source: 1 = frame complete, 0 = buffer empty |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Word to send |
| irq_ack | input | 1 | Clears the interrupt request |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_idle | output | 1 | No frame is shifting and no word is waiting |
| irq | output | 1 | Latched interrupt request |

## Verification
The hardest state to reach from the ports is a word held in the buffer while clear-to-send is deasserted at the exact end of the preceding frame. At that moment the line must stay high, buf_empty must stay low and tx_idle must stay low, all together. To get there, the bench sends a first frame and, in a parallel thread, queues the second word and raises cts_n partway through that first frame. It then watches the line through several bit times. After that it releases cts_n and counts the cycles until the start bit appears, which exposes the synchroniser depth. The same parallel-thread method drops tx_en in mid-frame, to show that the running frame finishes and the queued word is held back.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int DATA_W    = 9;
    localparam int MAX_FRAME = 13;
    localparam int CNT_W     = $clog2(MAX_FRAME + 1);

    typedef enum logic [1:0] {
        LEN_7   = 2'd0,
        LEN_8   = 2'd1,
        LEN_9   = 2'd2,
        LEN_RSV = 2'd3
    } len_e;

    typedef struct packed {
        len_e len;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } fmt_t;

    typedef struct packed {
        logic [MAX_FRAME-1:0] bits;
        logic [CNT_W-1:0]     nbits;
    } frame_t;

    function automatic int data_bits(input len_e l);
        case (l)
            LEN_7:   return 7;
            LEN_9:   return 9;
            default: return 8;
        endcase
    endfunction

    function automatic frame_t build_frame(input logic [DATA_W-1:0] d, input fmt_t f);
        frame_t fr;
        int     nd;
        logic   p;
        nd      = data_bits(f.len);
        p       = f.par_odd;
        fr.bits = '1;
        fr.bits[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nd) begin
                fr.bits[i+1] = d[i];
                p = p ^ d[i];
            end
        end
        if (f.par_en)
            fr.bits[nd+1] = p;
        fr.nbits = CNT_W'(1 + nd + (f.par_en ? 1 : 0) + (f.two_stop ? 2 : 1));
        return fr;
    endfunction

endpackage

// File: rtl/utx_sync2.sv
module utx_sync2 #(
    parameter int   STAGES    = 2,
    parameter logic RST_VALUE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VALUE;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VALUE}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/utx_baud.sv
module utx_baud #(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic             cnt_en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    logic [DIV_W-1:0] pre;
    logic [SUB_W-1:0] sub;
    logic             pre_wrap;

    assign pre_wrap = run && cnt_en && (pre == div);
    assign tick     = pre_wrap && (sub == SUB_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre <= '0;
            sub <= '0;
        end else if (cnt_en) begin
            if (pre == div) begin
                pre <= '0;
                sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/utx_framer.sv
module utx_framer
    import utx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   can_start,
    input  frame_t next_frame,
    output logic   load,
    output logic   active,
    output logic   txd,
    output logic   done_evt
);
    logic [MAX_FRAME-1:0] sh;
    logic [CNT_W-1:0]     left;
    logic                 frame_end;

    assign frame_end = active && tick && (left == CNT_W'(1));
    assign load      = can_start && (!active || frame_end);
    assign done_evt  = frame_end && !load;
    assign txd       = sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh     <= '1;
            left   <= '0;
        end else if (load) begin
            active <= 1'b1;
            sh     <= next_frame.bits;
            left   <= next_frame.nbits;
        end else if (frame_end) begin
            active <= 1'b0;
            sh     <= '1;
            left   <= '0;
        end else if (active && tick) begin
            sh     <= {1'b1, sh[MAX_FRAME-1:1]};
            left   <= left - 1'b1;
        end
    end
endmodule

// File: rtl/utx_irq.sv
module utx_irq (
    input  logic clk,
    input  logic rst,
    input  logic sel_done,
    input  logic done_evt,
    input  logic empty_evt,
    input  logic ack,
    output logic irq
);
    logic set_evt;

    assign set_evt = sel_done ? done_evt : empty_evt;

    always_ff @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (set_evt) irq <= 1'b1;
        else if (ack)     irq <= 1'b0;
    end
endmodule

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered
    import utx_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int OVS        = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             tx_en,
    input  logic [1:0]       len_sel,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             two_stop,
    input  logic             cts_en,
    input  logic             cts_n,
    input  logic             irq_on_done,
    input  logic             wr_stb,
    input  logic [8:0]       wr_data,
    input  logic             irq_ack,
    output logic             txd,
    output logic             buf_empty,
    output logic             tx_idle,
    output logic             irq
);
    logic              buf_full;
    logic [DATA_W-1:0] buf_word;
    logic              cts_s;
    logic              can_start;
    logic              load;
    logic              frame_active;
    logic              tick;
    logic              done_evt;
    logic              empty_evt;
    fmt_t              fmt;
    frame_t            next_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_full <= 1'b0;
            buf_word <= '0;
        end else begin
            if (wr_stb) begin
                buf_full <= 1'b1;
                buf_word <= wr_data;
            end else if (load) begin
                buf_full <= 1'b0;
            end
        end
    end

    utx_sync2 #(.STAGES(SYNC_DEPTH), .RST_VALUE(1'b1)) u_cts_sync (
        .clk (clk),
        .rst (rst),
        .d   (cts_n),
        .q   (cts_s)
    );

    always_comb begin
        fmt.len      = len_e'(len_sel);
        fmt.par_en   = par_en;
        fmt.par_odd  = par_odd;
        fmt.two_stop = two_stop;
        next_frame   = build_frame(buf_word, fmt);
    end

    assign can_start = buf_full && tx_en && (!cts_en || !cts_s);
    assign empty_evt = load && !wr_stb;

    utx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .run     (frame_active),
        .restart (load),
        .cnt_en  (cnt_en),
        .div     (baud_div),
        .tick    (tick)
    );

    utx_framer u_framer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .can_start  (can_start),
        .next_frame (next_frame),
        .load       (load),
        .active     (frame_active),
        .txd        (txd),
        .done_evt   (done_evt)
    );

    utx_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .sel_done  (irq_on_done),
        .done_evt  (done_evt),
        .empty_evt (empty_evt),
        .ack       (irq_ack),
        .irq       (irq)
    );

    assign buf_empty = !buf_full;
    assign tx_idle   = !frame_active && !buf_full;
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic buf_empty,
    input logic tx_idle,
    input logic txd,
    input logic irq,
    input logic irq_ack,
    input logic irq_on_done,
    input logic tx_en,
    input logic cts_en,
    input logic cts_s,
    input logic frame_active
);
    // R5: a write fills the buffer on the following cycle
    assert_wr_fills_R5: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !buf_empty);

    // R7: an idle transmitter holds the line high
    assert_idle_line_R7: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> txd);

    // R12: the request holds until acknowledged
    assert_irq_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack) |=> irq);

    // R10: no frame starts while transmit is disabled
    assert_txen_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !frame_active) |=> !frame_active);

    // R9: no frame starts while synchronised clear-to-send is high
    assert_cts_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (cts_en && cts_s && !frame_active) |=> !frame_active);

    // R2: every frame opens with a low start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_active) |-> !txd);

    // R11: in buffer-empty mode the request follows the buffer emptying
    assert_irq_empty_R11: assert property (@(posedge clk) disable iff (rst)
        ($rose(buf_empty) && $past(!irq_on_done)) |-> irq);
endmodule

bind uart_tx_buffered utx_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_stb       (wr_stb),
    .buf_empty    (buf_empty),
    .tx_idle      (tx_idle),
    .txd          (txd),
    .irq          (irq),
    .irq_ack      (irq_ack),
    .irq_on_done  (irq_on_done),
    .tx_en        (tx_en),
    .cts_en       (cts_en),
    .cts_s        (cts_s),
    .frame_active (frame_active)
);

// File: tb/uart_tx_buffered_tb.sv
module uart_tx_buffered_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       cnt_en = 1'b1;
    logic [7:0] baud_div;
    logic       tx_en, par_en, par_odd, two_stop, cts_en, cts_n, irq_on_done;
    logic [1:0] len_sel;
    logic       wr_stb, irq_ack;
    logic [8:0] wr_data;
    logic       txd, buf_empty, tx_idle, irq;

    int  total = 0;
    int  bad = 0;
    int  bt = 32;
    bit  half_rate = 0;
    bit  ph = 0;
    bit  timed_out = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        ph     <= ~ph;
        cnt_en <= half_rate ? ph : 1'b1;
    end

    uart_tx_buffered u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .baud_div(baud_div), .tx_en(tx_en),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .cts_en(cts_en), .cts_n(cts_n), .irq_on_done(irq_on_done), .wr_stb(wr_stb),
        .wr_data(wr_data), .irq_ack(irq_ack), .txd(txd), .buf_empty(buf_empty),
        .tx_idle(tx_idle), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [1:0] ls);
        return (ls == 2'd0) ? 7 : (ls == 2'd2) ? 9 : 8;
    endfunction

    function automatic int frame_len();
        return 1 + nbits_of(len_sel) + (par_en ? 1 : 0) + (two_stop ? 2 : 1);
    endfunction

    function automatic logic [12:0] expect_frame(input logic [8:0] d);
        logic [12:0] v;
        int   pos;
        int   ones;
        int   n;
        v = '1;
        n = nbits_of(len_sel);
        v[0] = 1'b0;
        pos = 1;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            v[pos] = d[i];
            ones += d[i] ? 1 : 0;
            pos++;
        end
        if (par_en) begin
            v[pos] = par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
            pos++;
        end
        return v;
    endfunction

    task automatic wr(input logic [8:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    // Samples a frame at bit centres; ends at the centre of the last bit.
    task automatic rx_frame(input bit seen, output logic [12:0] got);
        int n;
        int w;
        n   = frame_len();
        got = '1;
        if (!seen) begin
            w = 0;
            while (txd && w < 8 * bt) begin
                @(negedge clk);
                w++;
            end
            if (txd) begin
                got = 13'h1abc;
                return;
            end
        end
        repeat (bt / 2) @(negedge clk);
        got[0] = txd;
        for (int k = 1; k < n; k++) begin
            repeat (bt) @(negedge clk);
            got[k] = txd;
        end
    endtask

    task automatic t_reset();
        chk(txd == 1'b1,      "R13 txd",       32'(txd), 32'd1);
        chk(buf_empty == 1'b1, "R13 buf_empty", 32'(buf_empty), 32'd1);
        chk(tx_idle == 1'b1,  "R13 tx_idle",   32'(tx_idle), 32'd1);
        chk(irq == 1'b0,      "R13 irq",       32'(irq), 32'd0);
    endtask

    task automatic t_bittime(input logic [7:0] n, input bit half);
        int cnt;
        int exp;
        baud_div  = n;
        half_rate = half;
        exp = 16 * (int'(n) + 1) * (half ? 2 : 1);
        bt  = exp;
        len_sel = 2'd1; par_en = 0; two_stop = 0;
        wr(9'h001);
        @(negedge clk);
        cnt = 0;
        while (!txd && cnt < 4 * exp) begin
            cnt++;
            @(negedge clk);
        end
        if (half)
            chk(cnt == exp || cnt == exp - 1, "R1 bit time half rate", 32'(cnt), 32'(exp));
        else
            chk(cnt == exp, "R1 bit time", 32'(cnt), 32'(exp));
        while (!tx_idle) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_format(input logic [1:0] ls, input bit pe, input bit po,
                            input bit ts, input logic [8:0] d, input string tag);
        logic [12:0] got;
        logic [12:0] exp;
        len_sel = ls; par_en = pe; par_odd = po; two_stop = ts;
        exp = expect_frame(d);
        wr(d);
        chk(buf_empty == 1'b0, "R5 buf_empty low after write", 32'(buf_empty), 32'd0);
        @(negedge clk);
        chk(txd == 1'b0, "R2 start bit", 32'(txd), 32'd0);
        chk(buf_empty == 1'b1 && tx_idle == 1'b0, "R5/R7 handed to shifter",
            {30'd0, buf_empty, tx_idle}, 32'd2);
        rx_frame(1'b1, got);
        chk(got == exp, tag, 32'(got), 32'(exp));
        repeat (bt / 2 + 2) @(negedge clk);
        chk(tx_idle == 1'b1 && txd == 1'b1, "R7 idle after stop",
            {30'd0, tx_idle, txd}, 32'd3);
    endtask

    task automatic t_back2back();
        logic [12:0] g1, g2;
        len_sel = 2'd1; par_en = 1; par_odd = 0; two_stop = 0; cts_en = 0;
        wr(9'h0C3);
        fork
            rx_frame(1'b0, g1);
            begin
                repeat (6) @(negedge clk);
                wr(9'h05A);
                chk(buf_empty == 1'b0, "R5 second word queued", 32'(buf_empty), 32'd0);
            end
        join
        chk(g1 == expect_frame(9'h0C3), "R5 first of pair", 32'(g1), 32'(expect_frame(9'h0C3)));
        repeat (bt / 2) @(negedge clk);
        chk(txd == 1'b0, "R8 no gap between frames", 32'(txd), 32'd0);
        rx_frame(1'b1, g2);
        chk(g2 == expect_frame(9'h05A), "R8 second of pair", 32'(g2), 32'(expect_frame(9'h05A)));
        while (!tx_idle) @(negedge clk);
    endtask

    task automatic t_cts();
        logic [12:0] g;
        int lat;
        len_sel = 2'd1; par_en = 0; two_stop = 0; cts_en = 1;
        @(negedge clk); cts_n = 1'b1;
        wr(9'h0A7);
        repeat (100) @(negedge clk);
        chk(txd == 1'b1 && buf_empty == 1'b0, "R9 held while cts high",
            {30'd0, txd, buf_empty}, 32'd2);
        cts_n = 1'b0;
        lat = 0;
        while (txd && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 3, "R9 start latency after cts low", 32'(lat), 32'd3);
        rx_frame(1'b1, g);
        chk(g == expect_frame(9'h0A7), "R9 frame after release", 32'(g), 32'(expect_frame(9'h0A7)));
        while (!tx_idle) @(negedge clk);
        // stall between two queued frames
        wr(9'h011);
        fork
            rx_frame(1'b0, g);
            begin
                repeat (6) @(negedge clk);
                wr(9'h0EE);
                repeat (bt) @(negedge clk);
                cts_n = 1'b1;
            end
        join
        chk(g == expect_frame(9'h011), "R9 frame before stall", 32'(g), 32'(expect_frame(9'h011)));
        repeat (3 * bt) @(negedge clk);
        chk(txd == 1'b1 && buf_empty == 1'b0 && tx_idle == 1'b0, "R9/R7 stalled at boundary",
            {29'd0, txd, buf_empty, tx_idle}, 32'd4);
        cts_n = 1'b0;
        lat = 0;
        while (txd && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 3, "R9 restart latency", 32'(lat), 32'd3);
        rx_frame(1'b1, g);
        chk(g == expect_frame(9'h0EE), "R9 frame after stall", 32'(g), 32'(expect_frame(9'h0EE)));
        while (!tx_idle) @(negedge clk);
        cts_en = 0;
    endtask

    task automatic t_txen();
        logic [12:0] g;
        int lat;
        bit stayed;
        len_sel = 2'd1; par_en = 0; two_stop = 0;
        @(negedge clk); tx_en = 1'b0;
        wr(9'h033);
        wr(9'h0C8);
        chk(buf_empty == 1'b0, "R6 buffer still full after overwrite", 32'(buf_empty), 32'd0);
        stayed = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!txd) stayed = 0;
        end
        chk(stayed, "R10 no frame while disabled", 32'(stayed), 32'd1);
        tx_en = 1'b1;
        lat = 0;
        while (txd && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 1, "R10 start after enable", 32'(lat), 32'd1);
        rx_frame(1'b1, g);
        chk(g == expect_frame(9'h0C8), "R6 last word sent", 32'(g), 32'(expect_frame(9'h0C8)));
        repeat (2 * bt) @(negedge clk);
        chk(tx_idle == 1'b1 && txd == 1'b1, "R6 only one frame", {30'd0, tx_idle, txd}, 32'd3);
        // disable in mid-frame
        wr(9'h096);
        fork
            rx_frame(1'b0, g);
            begin
                repeat (6) @(negedge clk);
                wr(9'h069);
                repeat (bt) @(negedge clk);
                tx_en = 1'b0;
            end
        join
        chk(g == expect_frame(9'h096), "R10 running frame finishes", 32'(g), 32'(expect_frame(9'h096)));
        repeat (3 * bt) @(negedge clk);
        chk(txd == 1'b1 && buf_empty == 1'b0, "R10 queued word held", {30'd0, txd, buf_empty}, 32'd2);
        tx_en = 1'b1;
        rx_frame(1'b0, g);
        chk(g == expect_frame(9'h069), "R10 held word sent after enable", 32'(g), 32'(expect_frame(9'h069)));
        while (!tx_idle) @(negedge clk);
    endtask

    task automatic t_irq();
        logic [12:0] g;
        len_sel = 2'd1; par_en = 0; two_stop = 0;
        irq_on_done = 1'b0;
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk(irq == 1'b0, "R12 ack clears", 32'(irq), 32'd0);
        wr(9'h044);
        @(negedge clk);
        chk(irq == 1'b1, "R11 irq on buffer empty", 32'(irq), 32'd1);
        rx_frame(1'b1, g);
        repeat (bt) @(negedge clk);
        chk(irq == 1'b1, "R12 irq held", 32'(irq), 32'd1);
        irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk(irq == 1'b0, "R12 ack clears held irq", 32'(irq), 32'd0);
        irq_on_done = 1'b1;
        wr(9'h0BB);
        @(negedge clk);
        chk(irq == 1'b0, "R11 no irq at load in done mode", 32'(irq), 32'd0);
        rx_frame(1'b1, g);
        chk(irq == 1'b0, "R11 no irq during stop bit", 32'(irq), 32'd0);
        repeat (bt / 2 + 1) @(negedge clk);
        chk(irq == 1'b1 && tx_idle == 1'b1, "R11 irq on transmit complete",
            {30'd0, irq, tx_idle}, 32'd3);
        irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk(irq == 1'b0, "R12 final ack", 32'(irq), 32'd0);
    endtask

    task automatic run_all();
        rst = 1'b1;
        baud_div = 8'd1; tx_en = 1'b1; len_sel = 2'd1; par_en = 0; par_odd = 0;
        two_stop = 0; cts_en = 0; cts_n = 1'b0; irq_on_done = 0;
        wr_stb = 0; wr_data = '0; irq_ack = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bittime(8'd0, 1'b0);
        t_bittime(8'd1, 1'b0);
        t_bittime(8'd2, 1'b1);
        half_rate = 0; baud_div = 8'd1; bt = 32;
        repeat (4) @(negedge clk);
        t_format(2'd1, 0, 0, 0, 9'h0A5, "R2 8-bit frame");
        t_format(2'd0, 1, 0, 0, 9'h053, "R3 7-bit even parity");
        t_format(2'd2, 1, 1, 1, 9'h1C6, "R4 9-bit odd parity two stops");
        t_format(2'd1, 1, 1, 1, 9'h000, "R3 odd parity all zero");
        t_format(2'd3, 0, 0, 1, 9'h13C, "R2 code 3 as 8-bit");
        t_back2back();
        t_cts();
        t_txen();
        t_irq();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule